// File: doc/BRIEF.md
# Ternary Switch Sequence Synthesizer

This block takes the numerator `a` of a target probability `a/3^N` and works out a chain of random switches that is closed with exactly that probability. Each switch in the chain closes with probability 1/3 or 2/3, and each one is joined to the rest of the network either in series or in parallel. The block returns the chain one switch per clock cycle over a valid/ready stream. The first record it sends is the outermost switch, and the last record is the innermost one.

At each step the block compares the remaining numerator with one third and two thirds of the current range. That comparison, together with the parity of the numerator in the middle third, fixes both the switch type and the joining rule. A numerator whose lowest trit is zero is first reduced, so a fraction that needs `k` trits produces exactly `k` switches. That count is the smallest possible.

A request may also ask for an evaluation. In that case the block replays the stored chain from the innermost switch outward. It draws one event per switch from an exact 1/3 source, built from a pseudo-random two-bit code with one code value rejected. It then returns a single Bernoulli sample of the whole network.

Top module: `trit_switch_synth`

## Requirements
- R1: A request with `req_num` equal to 0 or at least 3^N is rejected. `err` is high for exactly one cycle, beginning the cycle after acceptance. No step is emitted, and `req_ready` stays high.
- R2: For a valid numerator, let `k` be N minus the number of trailing zero trits of `a`. Exactly `k` step records are sent, and `step_last` is 1 only on the k-th record. After the last record is accepted, `step_valid` falls.
- R3: Step encoding: `step_par` 1 means parallel and 0 means series. `step_hi` 1 means a 2/3 switch and 0 means a 1/3 switch. For the reduced numerator `a` with unit `u = 3^(k-1)`, the first step is chosen as follows:
  - `a <= u`: series 1/3.
  - `u < a <= 2u` and `a` odd: parallel 1/3.
  - `u < a <= 2u` and `a` even: series 2/3.
  - `a > 2u`: parallel 2/3.
  The final step is always series.
- R4: Rebuild the probability from the records, innermost first, starting at 1. A series switch `p` maps `P` to `pP`, and a parallel switch maps `P` to `p + (1-p)P`. The result equals `a/3^N` exactly.
- R5: While `step_valid` is high and `step_ready` is low, the record and `step_valid` hold unchanged.
- R6: `req_ready` is high only when idle. It is low whenever a step record is being offered.
- R7: When `req_eval` was set at acceptance, `eval_valid` pulses for exactly one cycle after the last record is taken. When `req_eval` was clear, no pulse occurs.
- R8: The evaluated sample `eval_bit` is 1 with probability `a/3^N`. The switch events come from a 1/3 source that rejects one of four code values.
- R9: After reset, `step_valid`, `eval_valid` and `err` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_num | input | NUM_W | Numerator of the target over 3^N |
| req_eval | input | 1 | Also produce one random sample of the network |
| step_valid | output | 1 | Step record offered |
| step_ready | input | 1 | Consumer takes the step record |
| step_par | output | 1 | 1 parallel, 0 series |
| step_hi | output | 1 | 1 switch of 2/3, 0 switch of 1/3 |
| step_last | output | 1 | Innermost (final) switch |
| err | output | 1 | One-cycle pulse on a rejected numerator |
| eval_valid | output | 1 | One-cycle pulse carrying the sample |
| eval_bit | output | 1 | Bernoulli sample of the synthesized network |

## Verification
The bench uses the default of four trits, giving a 7-bit numerator port. This lets it sweep every numerator from 1 to 80. For each one it checks the switch count, the first-step rule and an exact rational rebuild of the probability. The 7-bit port can also carry out-of-range codes such as 81 and 127, which the bench uses to check rejection. Sampling runs at 1/81, 40/81 and 80/81 test that the evaluation replay leans the right way at both extremes and near one half.

// File: rtl/trit_synth_pkg.sv
package trit_synth_pkg;

  function automatic int unsigned pow3(input int unsigned e);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < e; i++) r = r * 3;
    return r;
  endfunction

  typedef struct packed {
    logic par;
    logic hi;
  } sw_step_t;

endpackage

// File: rtl/tss_decide.sv
module tss_decide
  import trit_synth_pkg::*;
#(
  parameter int NUM_W = 7
) (
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] unit,
  output sw_step_t         step,
  output logic [NUM_W-1:0] next_num
);
  localparam int EXT_W = NUM_W + 1;

  logic [EXT_W-1:0] num_x, unit_x, two_u, diff;

  always_comb begin
    num_x  = {1'b0, num};
    unit_x = {1'b0, unit};
    two_u  = {unit, 1'b0};
    diff   = '0;
    if (num_x <= unit_x) begin
      step     = '{par: 1'b0, hi: 1'b0};
      next_num = num;
    end else if (num_x > two_u) begin
      step     = '{par: 1'b1, hi: 1'b1};
      diff     = num_x - two_u;
      next_num = diff[NUM_W-1:0];
    end else if (num[0]) begin
      step     = '{par: 1'b1, hi: 1'b0};
      diff     = num_x - unit_x;
      next_num = diff[NUM_W:1];
    end else begin
      step     = '{par: 1'b0, hi: 1'b1};
      next_num = num_x[NUM_W:1];
    end
  end
endmodule

// File: rtl/tss_store.sv
module tss_store
  import trit_synth_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  sw_step_t         wdata,
  input  logic [PTR_W-1:0] raddr,
  output sw_step_t         rdata
);
  sw_step_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tss_third_src.sv
module tss_third_src #(
  parameter int               LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS  = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  output logic usable,
  output logic hit
);
  localparam int MID = LFSR_W / 2;

  logic [LFSR_W-1:0] lfsr;
  logic [1:0]        code;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else if (lfsr[0]) lfsr <= (lfsr >> 1) ^ TAPS;
    else lfsr <= lfsr >> 1;
  end

  assign code   = {lfsr[MID], lfsr[0]};
  assign usable = (code != 2'b11);
  assign hit    = (code == 2'b00);
endmodule

// File: rtl/trit_switch_synth.sv
module trit_switch_synth
  import trit_synth_pkg::*;
#(
  parameter int               N_TRITS   = 4,
  parameter int               LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int unsigned      FULL      = pow3(N_TRITS),
  localparam int               NUM_W     = $clog2(FULL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NUM_W-1:0] req_num,
  input  logic             req_eval,
  output logic             step_valid,
  input  logic             step_ready,
  output logic             step_par,
  output logic             step_hi,
  output logic             step_last,
  output logic             err,
  output logic             eval_valid,
  output logic             eval_bit
);
  localparam int K_W   = $clog2(N_TRITS + 1);
  localparam int PTR_W = (N_TRITS > 1) ? $clog2(N_TRITS) : 1;
  localparam logic [NUM_W-1:0] TOP_UNIT = NUM_W'(FULL / 3);
  localparam logic [NUM_W-1:0] LIMIT    = NUM_W'(FULL);

  typedef enum logic [2:0] {
    ST_IDLE, ST_NORM, ST_EMIT, ST_DRAIN, ST_LOAD, ST_EVAL
  } state_t;

  state_t           state;
  logic [NUM_W-1:0] cur_num, unit;
  logic [K_W-1:0]   k_left;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             eval_req, acc;

  sw_step_t         dec_step, mem_q;
  logic [NUM_W-1:0] dec_next;
  logic             emit_fire, rnd_ok, rnd_hit, ev_bit, acc_next;

  tss_decide #(.NUM_W(NUM_W)) u_decide (
    .num(cur_num), .unit(unit), .step(dec_step), .next_num(dec_next)
  );

  assign emit_fire = (state == ST_EMIT) && (!step_valid || step_ready);

  tss_store #(.DEPTH(N_TRITS), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(emit_fire), .waddr(wr_ptr), .wdata(dec_step),
    .raddr(rd_ptr), .rdata(mem_q)
  );

  tss_third_src #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_rng (
    .clk(clk), .rst(rst), .usable(rnd_ok), .hit(rnd_hit)
  );

  // a 2/3 event is the complement of the 1/3 event on an accepted code
  assign ev_bit   = mem_q.hi ? !rnd_hit : rnd_hit;
  assign acc_next = mem_q.par ? (ev_bit | acc) : (ev_bit & acc);
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_num    <= '0;
      unit       <= '0;
      k_left     <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      eval_req   <= 1'b0;
      acc        <= 1'b0;
      step_valid <= 1'b0;
      step_par   <= 1'b0;
      step_hi    <= 1'b0;
      step_last  <= 1'b0;
      err        <= 1'b0;
      eval_valid <= 1'b0;
      eval_bit   <= 1'b0;
    end else begin
      err        <= 1'b0;
      eval_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          if (req_num == '0 || req_num >= LIMIT) begin
            err <= 1'b1;
          end else begin
            cur_num  <= req_num;
            unit     <= TOP_UNIT;
            k_left   <= K_W'(N_TRITS);
            eval_req <= req_eval;
            wr_ptr   <= '0;
            state    <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (cur_num % NUM_W'(3) == '0) begin
            cur_num <= cur_num / NUM_W'(3);
            unit    <= unit / NUM_W'(3);
            k_left  <= k_left - 1'b1;
          end else begin
            state <= ST_EMIT;
          end
        end
        ST_EMIT: if (emit_fire) begin
          step_valid <= 1'b1;
          step_par   <= dec_step.par;
          step_hi    <= dec_step.hi;
          step_last  <= (k_left == K_W'(1));
          cur_num    <= dec_next;
          unit       <= unit / NUM_W'(3);
          k_left     <= k_left - 1'b1;
          if (k_left == K_W'(1)) state <= ST_DRAIN;
          else wr_ptr <= wr_ptr + 1'b1;
        end
        ST_DRAIN: if (step_ready) begin
          step_valid <= 1'b0;
          rd_ptr     <= wr_ptr;
          acc        <= 1'b1;
          state      <= eval_req ? ST_LOAD : ST_IDLE;
        end
        ST_LOAD: state <= ST_EVAL;
        ST_EVAL: if (rnd_ok) begin
          acc <= acc_next;
          if (rd_ptr == '0) begin
            eval_valid <= 1'b1;
            eval_bit   <= acc_next;
            state      <= ST_IDLE;
          end else begin
            rd_ptr <= rd_ptr - 1'b1;
            state  <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trit_switch_synth_chk.sv
module trit_switch_synth_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic step_valid,
  input logic step_ready,
  input logic step_par,
  input logic step_hi,
  input logic step_last,
  input logic err,
  input logic eval_valid
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    step_valid && !step_ready |=> step_valid && $stable({step_par, step_hi, step_last}));

  // R6
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    step_valid |-> !req_ready);

  // R1
  reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> req_ready && !step_valid);

  // R3
  final_series_chk: assert property (@(posedge clk) disable iff (rst)
    step_valid && step_last |-> !step_par);

  // R7
  eval_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eval_valid |=> !eval_valid);

  // R2
  last_drain_chk: assert property (@(posedge clk) disable iff (rst)
    step_valid && step_ready && step_last |=> !step_valid);
endmodule

bind trit_switch_synth trit_switch_synth_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .step_valid(step_valid),
  .step_ready(step_ready), .step_par(step_par), .step_hi(step_hi),
  .step_last(step_last), .err(err), .eval_valid(eval_valid)
);

// File: tb/tb_trit_switch_synth.sv
`timescale 1ns/1ps
module tb_trit_switch_synth;
  localparam int N     = 4;
  localparam int FULL  = 81;
  localparam int NUM_W = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_eval = 1'b0, step_ready = 1'b0;
  logic [NUM_W-1:0] req_num = '0;
  logic req_ready, step_valid, step_par, step_hi, step_last, err, eval_valid, eval_bit;

  int checks = 0, errors = 0, cyc = 0;
  int rec_n;
  bit rec_par[16], rec_hi[16], rec_last[16];
  bit hold_bad, busy_bad, got_eval, extra_eval, last_eval;

  always #2.5 clk = ~clk;

  trit_switch_synth #(.N_TRITS(N)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_num(req_num), .req_eval(req_eval), .step_valid(step_valid),
    .step_ready(step_ready), .step_par(step_par), .step_hi(step_hi),
    .step_last(step_last), .err(err), .eval_valid(eval_valid), .eval_bit(eval_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_one(input int a, input bit ev);
    bit done = 0, pend = 0;
    bit pp = 0, ph = 0, pl = 0;
    rec_n = 0; hold_bad = 0; busy_bad = 0;
    got_eval = 0; extra_eval = 0; last_eval = 0;
    @(negedge clk);
    req_valid = 1; req_num = NUM_W'(a); req_eval = ev;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 200 && !done; i++) begin
      step_ready = ((i * 7 + a) % 3) != 0;
      if (pend) begin
        if (!step_valid || step_par != pp || step_hi != ph || step_last != pl) hold_bad = 1;
        pend = 0;
      end
      if (step_valid && req_ready) busy_bad = 1;
      if (step_valid && step_ready) begin
        if (rec_n < 16) begin
          rec_par[rec_n] = step_par; rec_hi[rec_n] = step_hi; rec_last[rec_n] = step_last;
        end
        rec_n++;
        if (step_last) done = 1;
      end else if (step_valid) begin
        pend = 1; pp = step_par; ph = step_hi; pl = step_last;
      end
      @(posedge clk);
      @(negedge clk);
    end
    step_ready = 0;
    for (int i = 0; i < 200; i++) begin
      if (eval_valid) begin
        if (got_eval) extra_eval = 1;
        got_eval = 1; last_eval = eval_bit;
      end
      if (req_ready && i > 30) break;
      @(negedge clk);
    end
  endtask

  // Full sweep: R2 count/last, R3 first step, R4 exact rebuild, R5 hold, R6 busy
  task automatic test_sweep();
    for (int a = 1; a < FULL; a++) begin
      int k = N, t = a, u = 1;
      bit ep, eh, last_ok = 1;
      longint num = 1, den = 1;
      while (t % 3 == 0) begin t = t / 3; k--; end
      for (int j = 1; j < k; j++) u = u * 3;
      run_one(a, 1'b0);
      check(rec_n == k, "R2 step count", rec_n, k);
      for (int j = 0; j < rec_n && j < 16; j++)
        if (rec_last[j] != (j == rec_n - 1)) last_ok = 0;
      check(last_ok, "R2 last flag placement", a, 1);
      if (t <= u) begin ep = 0; eh = 0; end
      else if (t > 2 * u) begin ep = 1; eh = 1; end
      else if (t % 2 == 1) begin ep = 1; eh = 0; end
      else begin ep = 0; eh = 1; end
      check(rec_par[0] == ep && rec_hi[0] == eh, "R3 first step {par,hi}",
            {rec_par[0], rec_hi[0]}, {ep, eh});
      check(rec_par[rec_n-1] == 0, "R3 final step series", rec_par[rec_n-1], 0);
      for (int j = rec_n - 1; j >= 0; j--) begin
        longint pn = rec_hi[j] ? 2 : 1;
        if (rec_par[j]) num = pn * den + (3 - pn) * num;
        else num = pn * num;
        den = den * 3;
      end
      check(num * FULL == longint'(a) * den, "R4 rebuilt probability numerator*81",
            int'(num * FULL / den), a);
      check(!hold_bad, "R5 stalled record held", hold_bad, 0);
      check(!busy_bad, "R6 req_ready low while offering", busy_bad, 0);
      check(!got_eval, "R7 no sample without request", got_eval, 0);
    end
  endtask

  task automatic test_reject(input int a);
    @(negedge clk);
    req_valid = 1; req_num = NUM_W'(a); req_eval = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(err == 1, "R1 err pulse", err, 1);
    check(req_ready == 1, "R1 stays idle", req_ready, 1);
    @(negedge clk);
    check(err == 0, "R1 err single cycle", err, 0);
    for (int i = 0; i < 6; i++) begin
      check(step_valid == 0, "R1 no step after reject", step_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic test_eval(input int a, input int runs, input int lo, input int hi);
    int ones = 0;
    for (int r = 0; r < runs; r++) begin
      run_one(a, 1'b1);
      if (!got_eval || extra_eval)
        check(0, "R7 single sample pulse", {got_eval, extra_eval}, 2);
      if (last_eval) ones++;
    end
    check(ones >= lo && ones <= hi, "R8 sample frequency", ones, (runs * a) / FULL);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(step_valid == 0, "R9 reset step_valid", step_valid, 0);
    check(eval_valid == 0, "R9 reset eval_valid", eval_valid, 0);
    check(err == 0, "R9 reset err", err, 0);
    check(req_ready == 1, "R9 reset req_ready", req_ready, 1);
    test_reject(0);
    test_reject(81);
    test_reject(127);
    test_sweep();
    test_eval(1, 200, 0, 20);
    test_eval(80, 200, 180, 200);
    test_eval(40, 200, 50, 150);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule